// File: doc/BRIEF.md
# Serial Command to Bus Master Bridge

This block sits behind a UART receiver and transmitter and turns a stream of command bytes into bus transactions. A host sends a short header: an operation byte, a word count and a 32-bit word address. The block then runs one bus cycle per word on a classic single-master bus port. On writes the data comes from the host. On reads the data goes back to the host.

Data words travel as four bytes each, most significant byte first, in both directions. The word address steps by one after every beat of a burst. Received bytes have no ready signal. They are taken only while the engine is parsing a header or collecting write data. Any other byte is dropped, so the host has to pace its data against the bus. Read data leaves on a valid/ready byte stream, and the engine waits for the host side before it fetches the next word.

Top module: `ser_bus_bridge`

## Requirements
- R1: An idle engine starts a write on byte 0x01 and a read on byte 0x02. Any other byte received while idle is discarded with no bus cycle and no transmitted byte, and the engine stays idle.
- R2: After the operation byte, the next received byte is the burst length in words. The four bytes after it form the 32-bit word address, first byte most significant. The burst then runs exactly that many bus beats.
- R3: For a write, each group of four received data bytes (first byte in bits 31:24) becomes one bus write of that 32-bit word.
- R4: For a read, each word returned on the bus is sent out as four bytes, bits 31:24 first and bits 7:0 last.
- R5: Beat i of a burst (counting from 0) uses word address base+i, with 32-bit wrap-around.
- R6: A burst length byte of 0 transfers 256 words.
- R7: Each bus cycle raises cyc and stb together with all four byte selects set. It holds address, write data and write enable steady until ack. cyc drops in the cycle after ack.
- R8: A presented output byte stays valid and unchanged until ready is seen. No bus cycle is active while an output byte is pending, so the next read word is fetched only after all four bytes of the previous word are accepted.
- R9: A write command produces no output bytes.
- R10: Reset (rst_ni low) clears cyc, stb and the output valid at once, abandons any partial command, and leaves the engine idle.
- R11: Bytes that arrive while the engine is running a bus cycle or sending read data are dropped and do not start a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid for one cycle |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | Byte to transmit is valid |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| wb_adr_o | output | 32 | Bus word address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_sel_o | output | 4 | Byte selects |
| wb_we_o | output | 1 | Write enable |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The assertions check the bus handshake on every cycle: stb is only high with cyc, cyc is held with steady address, data and write enable until ack, and cyc drops after ack. They also check that a stalled output byte stays unchanged and that no bus cycle overlaps a pending output byte. Header decoding, byte order, address stepping, the 256-word meaning of length 0, the silence of writes, dropped bytes and recovery from reset mid-command depend on whole command sequences. Only the bench scenarios can show them, by comparing logged bus beats and collected output bytes against a shadow memory.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_ADDR,
    ST_WDAT,
    ST_WBUS,
    ST_RBUS,
    ST_SEND
  } bb_state_e;
endpackage

// File: rtl/bb_byte_pack.sv
// Collects NB bytes, first byte ends up most significant.
module bb_byte_pack #(
  parameter int unsigned NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic [7:0]      byte_i,
  output logic [NB*8-1:0] word_o,
  output logic            last_o
);
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned HW = (NB - 1) * 8;

  logic [HW-1:0] hold_q;
  logic [CW-1:0] cnt_q;

  assign word_o = {hold_q, byte_i};
  assign last_o = push_i && (cnt_q == CW'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (push_i) begin
      hold_q <= word_o[HW-1:0];
      cnt_q  <= last_o ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/bb_byte_unpack.sv
// Sends a word as NB bytes, most significant first, over valid/ready.
module bb_byte_unpack #(
  parameter int unsigned NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [NB*8-1:0] word_i,
  output logic [7:0]      byte_o,
  output logic            valid_o,
  input  logic            ready_i,
  output logic            done_o
);
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned WW = NB * 8;

  logic [WW-1:0] word_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic          fire;

  assign byte_o  = word_q[WW-1 -: 8];
  assign valid_o = valid_q;
  assign fire    = valid_q && ready_i;
  assign done_o  = fire && (cnt_q == CW'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      word_q  <= word_i;
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (fire) begin
      word_q  <= word_q << 8;
      cnt_q   <= cnt_q + CW'(1);
      if (done_o) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bb_wb_master.sv
// One bus cycle per request; outputs registered and held until ack.
module bb_wb_master #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   adr_i,
  input  logic [DW-1:0]   dat_i,
  output logic [AW-1:0]   wb_adr_o,
  output logic [DW-1:0]   wb_dat_o,
  output logic [DW/8-1:0] wb_sel_o,
  output logic            wb_we_o,
  output logic            wb_cyc_o,
  output logic            wb_stb_o,
  input  logic            wb_ack_i,
  output logic            done_o
);
  logic          cyc_q;
  logic          we_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] dat_q;

  assign wb_adr_o = adr_q;
  assign wb_dat_o = dat_q;
  assign wb_we_o  = we_q;
  assign wb_cyc_o = cyc_q;
  assign wb_stb_o = cyc_q;
  assign wb_sel_o = '1;
  assign done_o   = cyc_q && wb_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= 1'b0;
      we_q  <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
    end else if (cyc_q) begin
      if (wb_ack_i) cyc_q <= 1'b0;
    end else if (req_i) begin
      cyc_q <= 1'b1;
      we_q  <= we_i;
      adr_q <= adr_i;
      dat_q <= dat_i;
    end
  end
endmodule

// File: rtl/ser_bus_bridge.sv
module ser_bus_bridge #(
  parameter int unsigned ADDR_BYTES = 4,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned LEN_W      = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [7:0]                rx_data_i,
  input  logic                      rx_valid_i,
  output logic [7:0]                tx_data_o,
  output logic                      tx_valid_o,
  input  logic                      tx_ready_i,
  output logic [ADDR_BYTES*8-1:0]   wb_adr_o,
  output logic [WORD_BYTES*8-1:0]   wb_dat_o,
  input  logic [WORD_BYTES*8-1:0]   wb_dat_i,
  output logic [WORD_BYTES-1:0]     wb_sel_o,
  output logic                      wb_we_o,
  output logic                      wb_cyc_o,
  output logic                      wb_stb_o,
  input  logic                      wb_ack_i
);
  import bb_pkg::*;

  localparam int unsigned AW = ADDR_BYTES * 8;
  localparam int unsigned DW = WORD_BYTES * 8;

  bb_state_e         state_q, state_d;
  logic              is_wr_q, is_wr_d;
  logic [LEN_W-1:0]  beats_q, beats_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     wdat_q, wdat_d;

  logic [AW-1:0]     addr_word;
  logic              addr_last;
  logic [DW-1:0]     dat_word;
  logic              dat_last;
  logic              bus_req, bus_done;
  logic              tx_done;

  bb_byte_pack #(.NB(ADDR_BYTES)) u_addr_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .push_i (rx_valid_i && state_q == ST_ADDR),
    .byte_i (rx_data_i),
    .word_o (addr_word),
    .last_o (addr_last)
  );

  bb_byte_pack #(.NB(WORD_BYTES)) u_dat_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .push_i (rx_valid_i && state_q == ST_WDAT),
    .byte_i (rx_data_i),
    .word_o (dat_word),
    .last_o (dat_last)
  );

  assign bus_req = (state_q == ST_WBUS) || (state_q == ST_RBUS);

  bb_wb_master #(.AW(AW), .DW(DW)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req),
    .we_i     (state_q == ST_WBUS),
    .adr_i    (addr_q),
    .dat_i    (wdat_q),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_sel_o (wb_sel_o),
    .wb_we_o  (wb_we_o),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_ack_i (wb_ack_i),
    .done_o   (bus_done)
  );

  bb_byte_unpack #(.NB(WORD_BYTES)) u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (bus_done && state_q == ST_RBUS),
    .word_i  (wb_dat_i),
    .byte_o  (tx_data_o),
    .valid_o (tx_valid_o),
    .ready_i (tx_ready_i),
    .done_o  (tx_done)
  );

  always_comb begin
    state_d = state_q;
    is_wr_d = is_wr_q;
    beats_d = beats_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    unique case (state_q)
      ST_IDLE: if (rx_valid_i) begin
        if (rx_data_i == OP_WRITE) begin
          is_wr_d = 1'b1;
          state_d = ST_LEN;
        end else if (rx_data_i == OP_READ) begin
          is_wr_d = 1'b0;
          state_d = ST_LEN;
        end
      end
      ST_LEN: if (rx_valid_i) begin
        beats_d = LEN_W'(rx_data_i);
        state_d = ST_ADDR;
      end
      ST_ADDR: if (addr_last) begin
        addr_d  = addr_word;
        state_d = is_wr_q ? ST_WDAT : ST_RBUS;
      end
      ST_WDAT: if (dat_last) begin
        wdat_d  = dat_word;
        state_d = ST_WBUS;
      end
      ST_WBUS: if (bus_done) begin
        // length 0 wraps to full counter range
        addr_d  = addr_q + AW'(1);
        beats_d = beats_q - LEN_W'(1);
        state_d = (beats_q == LEN_W'(1)) ? ST_IDLE : ST_WDAT;
      end
      ST_RBUS: if (bus_done) begin
        addr_d  = addr_q + AW'(1);
        beats_d = beats_q - LEN_W'(1);
        state_d = ST_SEND;
      end
      ST_SEND: if (tx_done) begin
        state_d = (beats_q == '0) ? ST_IDLE : ST_RBUS;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      beats_q <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      is_wr_q <= is_wr_d;
      beats_q <= beats_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
    end
  end
endmodule

// File: rtl/bb_chk.sv
module bb_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wb_cyc_o,
  input logic          wb_stb_o,
  input logic          wb_ack_i,
  input logic          wb_we_o,
  input logic [AW-1:0] wb_adr_o,
  input logic [DW-1:0] wb_dat_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_o
);
  // R7
  stb_in_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);

  // R7
  cyc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && wb_stb_o && $stable(wb_adr_o)
                                 && $stable(wb_dat_o) && $stable(wb_we_o)));

  // R7
  cyc_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R8
  tx_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !wb_cyc_o);
endmodule

bind ser_bus_bridge bb_chk #(.AW(ADDR_BYTES*8), .DW(WORD_BYTES*8)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wb_cyc_o   (wb_cyc_o),
  .wb_stb_o   (wb_stb_o),
  .wb_ack_i   (wb_ack_i),
  .wb_we_o    (wb_we_o),
  .wb_adr_o   (wb_adr_o),
  .wb_dat_o   (wb_dat_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o)
);

// File: tb/sim_ser_bus_bridge.sv
`timescale 1ns/1ps
module sim_ser_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [31:0] wb_adr, wb_dwr, wb_drd;
  logic [3:0]  wb_sel;
  logic        wb_we, wb_cyc, wb_stb, wb_ack;

  int checks = 0;
  int errors = 0;
  int n_bus  = 0;
  int n_tx   = 0;
  int ready_mode = 0;   // 0 always, 1 random, 2 stalled
  bit ack_en = 1'b1;
  int dly = 0;

  logic [31:0] mem     [256];
  logic [31:0] exp_mem [256];
  logic [31:0] log_adr [1024];
  logic [31:0] log_dat [1024];
  logic        log_we  [1024];
  logic [7:0]  tx_log  [2048];

  always #2.5 clk = ~clk;

  ser_bus_bridge u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .rx_data_i (rx_data), .rx_valid_i (rx_valid),
    .tx_data_o (tx_data), .tx_valid_o (tx_valid), .tx_ready_i (tx_ready),
    .wb_adr_o (wb_adr), .wb_dat_o (wb_dwr), .wb_dat_i (wb_drd),
    .wb_sel_o (wb_sel), .wb_we_o (wb_we), .wb_cyc_o (wb_cyc),
    .wb_stb_o (wb_stb), .wb_ack_i (wb_ack)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // bus slave with random ack latency; a beat is logged on the edge the bridge sees ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_ack <= 1'b0;
      wb_drd <= '0;
      dly = 0;
    end else if (wb_ack) begin
      wb_ack <= 1'b0;
      chk(wb_sel == 4'hF, "R7 byte selects", 32'(wb_sel), 32'hF);
      if (wb_we) mem[wb_adr[7:0]] = wb_dwr;
      if (n_bus < 1024) begin
        log_adr[n_bus] = wb_adr;
        log_dat[n_bus] = wb_dwr;
        log_we[n_bus]  = wb_we;
      end
      n_bus++;
    end else if (wb_cyc && wb_stb && ack_en) begin
      if (dly == 0) begin
        wb_ack <= 1'b1;
        wb_drd <= mem[wb_adr[7:0]];
        dly = $urandom % 3;
      end else begin
        dly = dly - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (n_tx < 2048) tx_log[n_tx] = tx_data;
      n_tx++;
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = 1'($urandom % 2);
      default: tx_ready = 1'b0;
    endcase
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat ($urandom % 2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [7:0] len,
                          input logic [31:0] a);
    send_byte(op);
    send_byte(len);
    for (int k = 0; k < 4; k++) send_byte(a[31-8*k -: 8]);
  endtask

  function automatic int beats_of(input logic [7:0] len);
    return (len == 8'd0) ? 256 : int'(len);
  endfunction

  task automatic do_write(input logic [31:0] a, input logic [7:0] len);
    int n, nb, nt;
    logic [31:0] w;
    logic [7:0] ix;
    n = beats_of(len);
    nb = n_bus;
    nt = n_tx;
    send_hdr(8'h01, len, a);
    for (int i = 0; i < n; i++) begin
      w = $urandom;
      ix = 8'(a + 32'(i));
      exp_mem[ix] = w;
      for (int k = 0; k < 4; k++) send_byte(w[31-8*k -: 8]);
      wait (n_bus == nb + i + 1);
    end
    for (int i = 0; i < n; i++) begin
      ix = 8'(a + 32'(i));
      chk(log_we[nb+i] == 1'b1, "R3 write enable", 32'(log_we[nb+i]), 32'd1);
      chk(log_dat[nb+i] == exp_mem[ix], "R3 write data", log_dat[nb+i], exp_mem[ix]);
      chk(log_adr[nb+i] == a + 32'(i), "R5 write address", log_adr[nb+i], a + 32'(i));
    end
    repeat (6) @(negedge clk);
    chk(n_bus - nb == n, (len == 0) ? "R6 write beat count" : "R2 write beat count",
        32'(n_bus - nb), 32'(n));
    chk(n_tx == nt, "R9 write sent bytes", 32'(n_tx - nt), 32'd0);
  endtask

  task automatic do_read(input logic [31:0] a, input logic [7:0] len);
    int n, nb, nt;
    logic [31:0] got;
    logic [7:0] ix;
    n = beats_of(len);
    nb = n_bus;
    nt = n_tx;
    send_hdr(8'h02, len, a);
    wait (n_tx == nt + 4 * n);
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ix = 8'(a + 32'(i));
      got = {tx_log[nt+4*i], tx_log[nt+4*i+1], tx_log[nt+4*i+2], tx_log[nt+4*i+3]};
      chk(got == exp_mem[ix], "R4 read bytes", got, exp_mem[ix]);
      chk(log_adr[nb+i] == a + 32'(i), "R5 read address", log_adr[nb+i], a + 32'(i));
      chk(log_we[nb+i] == 1'b0, "R4 read is not write", 32'(log_we[nb+i]), 32'd0);
    end
    chk(n_bus - nb == n, (len == 0) ? "R6 read beat count" : "R2 read beat count",
        32'(n_bus - nb), 32'(n));
    chk(n_tx - nt == 4 * n, "R4 read byte count", 32'(n_tx - nt), 32'(4 * n));
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    int nb, nt;
    logic [31:0] a, got;
    logic [7:0] len;
    void'($urandom(7));
    rst_n = 1'b0;
    rx_valid = 1'b0;
    rx_data = 8'h00;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!wb_cyc && !wb_stb, "R10 bus idle in reset", {30'd0, wb_cyc, wb_stb}, 32'd0);
    chk(!tx_valid, "R10 tx idle in reset", 32'(tx_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 unknown opcodes are discarded
    nb = n_bus; nt = n_tx;
    send_byte(8'h00); send_byte(8'h03); send_byte(8'hFF);
    send_byte(8'h80); send_byte(8'h7F); send_byte(8'h10);
    repeat (12) @(negedge clk);
    chk(n_bus == nb, "R1 no bus cycle on bad opcode", 32'(n_bus - nb), 32'd0);
    chk(n_tx == nt, "R1 no tx on bad opcode", 32'(n_tx - nt), 32'd0);

    // single word directed
    do_write(32'h1234_5678, 8'd1);
    do_read(32'h1234_5678, 8'd1);

    // random bursts, R8 with random backpressure
    for (int k = 0; k < 8; k++) begin
      len = 8'(1 + $urandom % 8);
      a = $urandom;
      ready_mode = k % 2;
      do_write(a, len);
      do_read(a, len);
    end

    // R6 length 0 means 256 words, across the 32-bit address wrap
    ready_mode = 1;
    do_write(32'hFFFF_FF80, 8'd0);
    do_read(32'hFFFF_FF80, 8'd0);

    // R11 bytes sent while output is stalled are dropped
    ready_mode = 2;
    nb = n_bus; nt = n_tx;
    send_hdr(8'h02, 8'd1, 32'h1234_5678);
    wait (tx_valid == 1'b1);
    send_hdr(8'h02, 8'd1, 32'h0000_0000);
    ready_mode = 0;
    wait (n_tx == nt + 4);
    repeat (20) @(negedge clk);
    got = {tx_log[nt], tx_log[nt+1], tx_log[nt+2], tx_log[nt+3]};
    chk(got == exp_mem[8'h78], "R4 stalled read bytes", got, exp_mem[8'h78]);
    chk(n_bus == nb + 1, "R11 busy bytes start no bus cycle", 32'(n_bus - nb), 32'd1);
    chk(n_tx == nt + 4, "R11 busy bytes send nothing", 32'(n_tx - nt), 32'd4);

    // R10 reset in the middle of a read
    ack_en = 1'b0;
    nb = n_bus; nt = n_tx;
    send_hdr(8'h02, 8'd2, 32'h0000_0040);
    repeat (4) @(negedge clk);
    chk(wb_cyc && wb_stb, "R7 cycle held without ack", {30'd0, wb_cyc, wb_stb}, 32'd3);
    rst_n = 1'b0;
    #1;
    chk(!wb_cyc && !wb_stb, "R10 reset clears bus", {30'd0, wb_cyc, wb_stb}, 32'd0);
    chk(!tx_valid, "R10 reset clears tx", 32'(tx_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ack_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(n_bus == nb && n_tx == nt, "R10 abandoned command is gone",
        32'(n_bus - nb + n_tx - nt), 32'd0);
    do_write(32'h0000_0040, 8'd2);
    do_read(32'h0000_0040, 8'd2);

    finish_sim();
  end
endmodule